// File: doc/BRIEF.md
# Serial EEPROM Autoload Controller

This block sits between a network controller and a small external serial EEPROM with a three-wire read protocol plus chip select. After reset it reads a fixed run of 16-bit words and hands each one to a shadow register file, which overrides the built-in configuration defaults. If the device does not answer, or if its first word does not carry the expected signature, the load stops and an absent flag tells the consumer to keep its defaults.

Software can start the load again with a command pulse. It can also take the four pins over through a bit-bang register and clock any operation by hand. The sequencer owns the pins while a load runs. At power-on the pin that carries data from the EEPROM is sampled once, and that sample records whether auxiliary power is present.

Top module: `eeprom_autoload`

## Requirements
- R1: While rst_ni is low, ee_cs_o, busy_o and sh_we_o are low. After rst_ni goes high, a load begins with no software action, and busy_o is high within 8 clock cycles.
- R2: Each read frame holds chip select high and sends a 1, then the opcode bits 1 and 0, then the word address MSB first. The address has 6 bits when big_dev_i is 0 and 8 bits when it is 1. The controller then samples a dummy 0 and 16 data bits MSB first, so a frame is 25 or 27 serial clocks long. Output data changes while the serial clock is low. Input data is sampled at the end of the clock-high half.
- R3: Inside a frame, ee_sk_o has a period of CLK_DIV clock cycles and is high only while ee_cs_o is high. Between consecutive words of one load, ee_cs_o stays low for at least CLK_DIV cycles.
- R4: A load reads NUM_WORDS words at addresses 0, 1, 2 and so on. Each word appears on sh_data_o, with sh_idx_o equal to its address, for exactly one cycle of sh_we_o.
- R5: If the dummy bit reads 1, the load stops. ee_cs_o goes low, absent_o goes to 1, busy_o goes to 0, and no further write strobe follows. absent_o returns to 0 when the next load starts.
- R6: If word 0 differs from SIGNATURE, the load ends in the same absent state, and word 0 is not written.
- R7: busy_o stays high from the start of a load until its last word is written or it aborts. A reload_i pulse starts a load only while busy_o is low. A pulse while busy_o is high has no effect.
- R8: With the bit-bang enable set and busy_o low, ee_cs_o, ee_sk_o and ee_mosi_o follow the bit-bang register. bb_miso_o returns ee_miso_i through a two-stage synchronizer.
- R9: A bit-bang register write (bb_we_i) while busy_o is high is ignored, and the register keeps its previous contents.
- R10: ee_miso_i is sampled once, on the fourth clock after reset release, into aux_pwr_o. aux_pwr_o does not change again until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| big_dev_i | input | 1 | 0: 6 address bits, 1: 8 address bits (static) |
| reload_i | input | 1 | Software load command pulse |
| bb_we_i | input | 1 | Bit-bang register write strobe |
| bb_en_i | input | 1 | Bit-bang enable field |
| bb_cs_i | input | 1 | Bit-bang chip select field |
| bb_sk_i | input | 1 | Bit-bang serial clock field |
| bb_mosi_i | input | 1 | Bit-bang output data field |
| bb_miso_o | output | 1 | Synchronized EEPROM data for software |
| ee_cs_o | output | 1 | EEPROM chip select |
| ee_sk_o | output | 1 | EEPROM serial clock |
| ee_mosi_o | output | 1 | Data to EEPROM |
| ee_miso_i | input | 1 | Data from EEPROM, also aux-power sense |
| busy_o | output | 1 | Load in progress |
| absent_o | output | 1 | Last load found no valid device |
| aux_pwr_o | output | 1 | Auxiliary power sensed at power-on |
| sh_we_o | output | 1 | Shadow register write strobe |
| sh_idx_o | output | IDX_W | Shadow register index |
| sh_data_o | output | 16 | Shadow register data |

## Verification
A behavioural EEPROM model answers loads from a computed content array, once for each address width and once with the content inverted. These runs separate a correct address length and bit order from shifted or reversed frames. Two runs cover the absent outcomes. In one the device is silent, so the pulled-up line fails the dummy bit. In the other the signature is wrong while the frame itself is well formed, which shows that each abort path works on its own. Stimulus that must be ignored is also driven: a reload and a bit-bang write while busy, followed by a low aux sense at power-on. A final software bit-bang read of one word confirms that the pins hand over cleanly to the register path.

// File: rtl/ee_pkg.sv
package ee_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_GAP, SQ_SHIFT} sq_state_e;
  localparam logic [2:0]  RD_CMD       = 3'b110;  // start bit, then read opcode
  localparam int unsigned ADDR_W_MAX   = 8;
  localparam int unsigned ADDR_W_SMALL = 6;
  localparam int unsigned DATA_W       = 16;
endpackage

// File: rtl/ee_tick.sv
module ee_tick #(
  parameter int unsigned CLK_DIV = 64,
  localparam int unsigned HALF = CLK_DIV / 2,
  localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ee_read_seq.sv
module ee_read_seq import ee_pkg::*; #(
  parameter int unsigned NUM_WORDS = 8,
  parameter logic [DATA_W-1:0] SIGNATURE = 16'h8129,
  localparam int unsigned IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic              big_dev_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              absent_o,
  output logic              cs_o,
  output logic              sk_o,
  output logic              mosi_o,
  output logic              wr_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [DATA_W-1:0] wr_data_o
);
  localparam int unsigned CMD_W = 3 + ADDR_W_MAX;
  localparam int unsigned BIT_W = $clog2(CMD_W + DATA_W);

  sq_state_e          st_q;
  logic               ph_q, gap_q, busy_q, absent_q, cs_q, sk_q;
  logic [BIT_W-1:0]   bit_q, cmd_len, last_bit;
  logic [IDX_W-1:0]   word_q;
  logic [CMD_W-1:0]   cmd_q, cmd_fmt;
  logic [DATA_W-1:0]  data_q, word_nx;
  logic [ADDR_W_MAX-1:0] addr;

  assign cmd_len  = big_dev_i ? BIT_W'(CMD_W) : BIT_W'(3 + ADDR_W_SMALL);
  assign last_bit = cmd_len + BIT_W'(DATA_W - 1);
  assign addr     = ADDR_W_MAX'(word_q);
  assign cmd_fmt  = big_dev_i ? {RD_CMD, addr}
                              : {RD_CMD, addr[ADDR_W_SMALL-1:0], {(ADDR_W_MAX-ADDR_W_SMALL){1'b0}}};
  assign word_nx  = {data_q[DATA_W-2:0], miso_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= SQ_IDLE; ph_q <= 1'b0; gap_q <= 1'b0; busy_q <= 1'b0; absent_q <= 1'b0;
      cs_q <= 1'b0; sk_q <= 1'b0; bit_q <= '0; word_q <= '0; cmd_q <= '0; data_q <= '0;
      wr_o <= 1'b0; wr_idx_o <= '0; wr_data_o <= '0;
    end else begin
      wr_o <= 1'b0;
      case (st_q)
        SQ_IDLE: if (start_i) begin
          st_q <= SQ_GAP; busy_q <= 1'b1; absent_q <= 1'b0; word_q <= '0; gap_q <= 1'b0;
        end
        SQ_GAP: if (tick_i) begin
          gap_q <= ~gap_q;
          if (gap_q) begin
            st_q <= SQ_SHIFT; cs_q <= 1'b1; cmd_q <= cmd_fmt; bit_q <= '0; ph_q <= 1'b0;
          end
        end
        SQ_SHIFT: if (tick_i) begin
          if (!ph_q) begin
            sk_q <= 1'b1; ph_q <= 1'b1;
          end else begin
            sk_q  <= 1'b0; ph_q <= 1'b0;
            cmd_q <= {cmd_q[CMD_W-2:0], 1'b0};
            bit_q <= bit_q + 1'b1;
            if (bit_q >= cmd_len) data_q <= word_nx;
            if (bit_q == cmd_len - 1'b1 && miso_i) begin
              // dummy bit not driven low: nothing answered
              st_q <= SQ_IDLE; cs_q <= 1'b0; busy_q <= 1'b0; absent_q <= 1'b1;
            end else if (bit_q == last_bit) begin
              cs_q <= 1'b0;
              if (word_q == '0 && word_nx != SIGNATURE) begin
                st_q <= SQ_IDLE; busy_q <= 1'b0; absent_q <= 1'b1;
              end else begin
                wr_o <= 1'b1; wr_idx_o <= word_q; wr_data_o <= word_nx;
                if (word_q == IDX_W'(NUM_WORDS - 1)) begin
                  st_q <= SQ_IDLE; busy_q <= 1'b0;
                end else begin
                  st_q <= SQ_GAP; gap_q <= 1'b0; word_q <= word_q + 1'b1;
                end
              end
            end
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy_o   = busy_q;
  assign absent_o = absent_q;
  assign cs_o     = cs_q;
  assign sk_o     = sk_q;
  assign mosi_o   = cmd_q[CMD_W-1];

  assert_strobe_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |=> !wr_o);
  assert_no_write_absent_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    absent_q |-> !wr_o);
  assert_sk_in_frame_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sk_q |-> cs_q);
  assert_idle_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !cs_q);
endmodule

// File: rtl/ee_pin_mux.sv
module ee_pin_mux (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic bb_we_i,
  input  logic bb_en_i,
  input  logic bb_cs_i,
  input  logic bb_sk_i,
  input  logic bb_mosi_i,
  input  logic seq_cs_i,
  input  logic seq_sk_i,
  input  logic seq_mosi_i,
  output logic ee_cs_o,
  output logic ee_sk_o,
  output logic ee_mosi_o
);
  logic [3:0] bb_q;  // {en, cs, sk, mosi}
  logic       use_bb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 bb_q <= '0;
    else if (bb_we_i && !busy_i) bb_q <= {bb_en_i, bb_cs_i, bb_sk_i, bb_mosi_i};
  end

  assign use_bb    = bb_q[3] && !busy_i;
  assign ee_cs_o   = use_bb ? bb_q[2] : seq_cs_i;
  assign ee_sk_o   = use_bb ? bb_q[1] : seq_sk_i;
  assign ee_mosi_o = use_bb ? bb_q[0] : seq_mosi_i;

  assert_bb_hold_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(bb_q));
  assert_seq_owns_pins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (ee_sk_o == seq_sk_i));
endmodule

// File: rtl/eeprom_autoload.sv
module eeprom_autoload #(
  parameter int unsigned CLK_DIV   = 64,
  parameter int unsigned NUM_WORDS = 8,
  parameter logic [15:0] SIGNATURE = 16'h8129,
  localparam int unsigned IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             big_dev_i,
  input  logic             reload_i,
  input  logic             bb_we_i,
  input  logic             bb_en_i,
  input  logic             bb_cs_i,
  input  logic             bb_sk_i,
  input  logic             bb_mosi_i,
  output logic             bb_miso_o,
  output logic             ee_cs_o,
  output logic             ee_sk_o,
  output logic             ee_mosi_o,
  input  logic             ee_miso_i,
  output logic             busy_o,
  output logic             absent_o,
  output logic             aux_pwr_o,
  output logic             sh_we_o,
  output logic [IDX_W-1:0] sh_idx_o,
  output logic [15:0]      sh_data_o
);
  logic       miso_s1, miso_s2, aux_done_q, aux_q, tick, start, busy;
  logic       seq_cs, seq_sk, seq_mosi;
  logic [1:0] por_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      miso_s1 <= 1'b0; miso_s2 <= 1'b0;
      por_cnt_q <= '0; aux_done_q <= 1'b0; aux_q <= 1'b0;
    end else begin
      miso_s1 <= ee_miso_i;
      miso_s2 <= miso_s1;
      if (!aux_done_q) begin
        por_cnt_q <= por_cnt_q + 1'b1;
        if (por_cnt_q == 2'd3) begin
          aux_q <= miso_s2; aux_done_q <= 1'b1;
        end
      end
    end
  end

  // power-on load follows the aux sample; software reloads only when idle
  assign start = (!aux_done_q && por_cnt_q == 2'd3) || (aux_done_q && reload_i && !busy);

  ee_tick #(.CLK_DIV(CLK_DIV)) u_tick (.clk_i, .rst_ni, .tick_o(tick));

  ee_read_seq #(.NUM_WORDS(NUM_WORDS), .SIGNATURE(SIGNATURE)) u_seq (
    .clk_i, .rst_ni, .tick_i(tick), .start_i(start), .big_dev_i, .miso_i(miso_s2),
    .busy_o(busy), .absent_o, .cs_o(seq_cs), .sk_o(seq_sk), .mosi_o(seq_mosi),
    .wr_o(sh_we_o), .wr_idx_o(sh_idx_o), .wr_data_o(sh_data_o));

  ee_pin_mux u_mux (
    .clk_i, .rst_ni, .busy_i(busy), .bb_we_i, .bb_en_i, .bb_cs_i, .bb_sk_i, .bb_mosi_i,
    .seq_cs_i(seq_cs), .seq_sk_i(seq_sk), .seq_mosi_i(seq_mosi),
    .ee_cs_o, .ee_sk_o, .ee_mosi_o);

  assign busy_o    = busy;
  assign aux_pwr_o = aux_q;
  assign bb_miso_o = miso_s2;

  assert_aux_once_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aux_done_q |=> $stable(aux_q));
  assert_reload_ignored_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && aux_done_q) |-> !start);
endmodule

// File: tb/sim_eeprom_autoload.sv
module sim_eeprom_autoload;
  localparam int unsigned CLK_DIV = 8;
  localparam int unsigned NW = 8;
  localparam logic [15:0] SIG = 16'hA55A;
  localparam int unsigned IW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic big_dev = 1'b0, reload = 1'b0;
  logic bb_we = 1'b0, bb_en = 1'b0, bb_cs = 1'b0, bb_sk = 1'b0, bb_mosi = 1'b0;
  logic bb_miso, ee_cs, ee_sk, ee_mosi, ee_miso, busy, absent, aux_pwr, sh_we;
  logic [IW-1:0] sh_idx;
  logic [15:0] sh_data;
  logic present = 1'b1, pull = 1'b1, m_dout = 1'b1;

  always #10 clk = ~clk;  // 50 MHz

  assign ee_miso = (ee_cs && present) ? m_dout : pull;

  eeprom_autoload #(.CLK_DIV(CLK_DIV), .NUM_WORDS(NW), .SIGNATURE(SIG)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .big_dev_i(big_dev), .reload_i(reload),
    .bb_we_i(bb_we), .bb_en_i(bb_en), .bb_cs_i(bb_cs), .bb_sk_i(bb_sk), .bb_mosi_i(bb_mosi),
    .bb_miso_o(bb_miso), .ee_cs_o(ee_cs), .ee_sk_o(ee_sk), .ee_mosi_o(ee_mosi),
    .ee_miso_i(ee_miso), .busy_o(busy), .absent_o(absent), .aux_pwr_o(aux_pwr),
    .sh_we_o(sh_we), .sh_idx_o(sh_idx), .sh_data_o(sh_data));

  int n_chk = 0, n_err = 0, frame_err = 0, viol = 0;
  bit done = 1'b0;
  logic [15:0] mem [256];
  logic [IW+15:0] exp_q [$];
  int addr_log [$];

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // EEPROM model
  int m_edges = 0, m_addr = 0;
  logic [10:0] m_cmd = '0;
  always @(posedge ee_cs) begin m_edges = 0; m_cmd = '0; end
  always @(negedge ee_cs) begin
    if (present && m_edges != 0 && m_edges != 19 + (big_dev ? 8 : 6)) frame_err++;  // R2
    m_dout = 1'b1;
  end
  always @(posedge ee_sk) if (ee_cs && present) begin
    automatic int a = big_dev ? 8 : 6;
    if (m_edges < 3 + a) begin
      m_cmd = {m_cmd[9:0], ee_mosi};
      if (m_edges == 2 + a) begin
        if (m_cmd[a+2 -: 3] != 3'b110) frame_err++;
        m_addr = int'(m_cmd) & ((1 << a) - 1);
        addr_log.push_back(m_addr);
        m_dout = 1'b0;
      end
    end else begin
      automatic int k = m_edges - (3 + a);
      m_dout = (k < 16) ? mem[m_addr][15-k] : 1'b0;
    end
    m_edges++;
  end

  // scoreboard monitor
  always @(negedge clk) if (rst_n && sh_we) begin
    if (exp_q.size() == 0) chk("R4", "unexpected write strobe", {16'h0, sh_data}, 32'hFFFF_FFFF);
    else begin
      automatic logic [IW+15:0] e = exp_q.pop_front();
      chk("R4", "write index", 32'(sh_idx), 32'(e[IW+15:16]));
      chk("R2", "write data", 32'(sh_data), 32'(e[15:0]));
    end
  end

  // timing monitor (R3)
  int lo_cnt = 0, sk_cnt = 0;
  logic cs_prev = 1'b0, sk_prev = 1'b0, sk_valid = 1'b0, fall_busy = 1'b0;
  always @(negedge clk) begin
    if (!rst_n) begin
      lo_cnt = 0; sk_cnt = 0; cs_prev = 1'b0; sk_prev = 1'b0; sk_valid = 1'b0; fall_busy = 1'b0;
    end else begin
      sk_cnt++;
      if (busy) begin
        if (ee_cs && !cs_prev && fall_busy && lo_cnt < CLK_DIV) viol++;
        if (ee_sk && !sk_prev && sk_valid && sk_cnt != CLK_DIV) viol++;
        if (!ee_cs && cs_prev) fall_busy = 1'b1;
      end else fall_busy = 1'b0;
      if (ee_cs && !cs_prev) sk_valid = 1'b0;
      if (ee_sk && !sk_prev) begin sk_valid = 1'b1; sk_cnt = 0; end
      if (ee_sk && !ee_cs) viol++;
      lo_cnt = ee_cs ? 0 : lo_cnt + 1;
      cs_prev = ee_cs; sk_prev = ee_sk;
    end
  end

  task automatic expect_load();
    for (int i = 0; i < NW; i++) exp_q.push_back({IW'(i), mem[i]});
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    chk("R1", "cs in reset", 32'(ee_cs), 32'd0);
    chk("R1", "busy in reset", 32'(busy), 32'd0);
    chk("R1", "strobe in reset", 32'(sh_we), 32'd0);
    rst_n = 1'b1;
  endtask

  task automatic wait_idle();
    int t = 0;
    while (busy && t < 20000) begin @(negedge clk); t++; end
    @(negedge clk);
  endtask

  task automatic pulse_reload();
    @(negedge clk); reload = 1'b1;
    @(negedge clk); reload = 1'b0;
  endtask

  task automatic check_load(input string tag);
    chk("R4", {tag, " pending words"}, 32'(exp_q.size()), 32'd0);
    for (int i = 0; i < NW; i++) begin
      if (addr_log.size() == 0) chk("R2", "address missing", 32'hFFFF, 32'(i));
      else chk("R2", {tag, " address order"}, 32'(addr_log.pop_front()), 32'(i));
    end
    chk("R2", {tag, " frame errors"}, 32'(frame_err), 32'd0);
    chk("R3", {tag, " timing violations"}, 32'(viol), 32'd0);
    chk("R5", {tag, " absent clear"}, 32'(absent), 32'd0);
  endtask

  task automatic bb_wr(input logic en, input logic cs, input logic sk, input logic d);
    @(negedge clk); bb_en = en; bb_cs = cs; bb_sk = sk; bb_mosi = d; bb_we = 1'b1;
    @(negedge clk); bb_we = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 16'h1357) ^ 16'h0F0F;
    mem[0] = SIG;

    // run 1: 6-bit address device, aux present
    expect_load();
    do_reset();
    repeat (8) @(negedge clk);
    chk("R1", "busy after reset", 32'(busy), 32'd1);
    wait_idle();
    check_load("small");
    chk("R10", "aux sensed high", 32'(aux_pwr), 32'd1);

    // run 2: 8-bit address device, inverted content; bit-bang write and reload while busy
    for (int i = 1; i < 256; i++) mem[i] = ~mem[i];
    big_dev = 1'b1;
    expect_load();
    do_reset();
    repeat (40) @(negedge clk);
    bb_wr(1'b1, 1'b1, 1'b1, 1'b1);
    pulse_reload();
    bb_en = 1'b0; bb_cs = 1'b0; bb_sk = 1'b0; bb_mosi = 1'b0;
    wait_idle();
    chk("R9", "cs after busy bit-bang write", 32'(ee_cs), 32'd0);
    chk("R9", "sk after busy bit-bang write", 32'(ee_sk), 32'd0);
    repeat (300) @(negedge clk);
    chk("R7", "no reload from busy pulse", 32'(busy), 32'd0);
    check_load("big");

    // run 3: software reload while idle
    expect_load();
    pulse_reload();
    @(negedge clk);
    chk("R7", "reload accepted when idle", 32'(busy), 32'd1);
    wait_idle();
    check_load("reload");

    // run 4: no device
    present = 1'b0;
    pulse_reload();
    repeat (2) @(negedge clk);
    wait_idle();
    chk("R5", "absent flag", 32'(absent), 32'd1);
    chk("R5", "busy cleared", 32'(busy), 32'd0);
    chk("R5", "cs released", 32'(ee_cs), 32'd0);
    chk("R5", "no writes", 32'(exp_q.size()), 32'd0);

    // run 5: signature mismatch
    present = 1'b1;
    mem[0] = ~SIG;
    pulse_reload();
    repeat (2) @(negedge clk);
    wait_idle();
    chk("R6", "absent on bad signature", 32'(absent), 32'd1);
    chk("R6", "busy cleared", 32'(busy), 32'd0);
    chk("R6", "single frame address", 32'(addr_log.size()), 32'd1);
    addr_log.delete();
    mem[0] = SIG;

    // run 6: aux sense low at power-on
    big_dev = 1'b0;
    pull = 1'b0;
    expect_load();
    do_reset();
    repeat (20) @(negedge clk);
    pull = 1'b1;
    wait_idle();
    chk("R10", "aux sensed low", 32'(aux_pwr), 32'd0);
    check_load("aux");
    chk("R10", "aux held after load", 32'(aux_pwr), 32'd0);

    // run 7: bit-bang read of word 3
    begin
      logic [8:0] cmd = {3'b110, 6'd3};
      logic [15:0] w = '0;
      bb_wr(1'b1, 1'b0, 1'b0, 1'b0);
      chk("R8", "bit-bang cs low", 32'(ee_cs), 32'd0);
      for (int i = 8; i >= 0; i--) begin
        bb_wr(1'b1, 1'b1, 1'b0, cmd[i]);
        bb_wr(1'b1, 1'b1, 1'b1, cmd[i]);
      end
      chk("R8", "bit-bang dummy bit", 32'(bb_miso), 32'd0);
      bb_wr(1'b1, 1'b1, 1'b0, 1'b0);
      for (int k = 15; k >= 0; k--) begin
        bb_wr(1'b1, 1'b1, 1'b1, 1'b0);
        w[k] = bb_miso;
        bb_wr(1'b1, 1'b1, 1'b0, 1'b0);
      end
      bb_wr(1'b1, 1'b0, 1'b0, 1'b0);
      bb_wr(1'b0, 1'b0, 1'b0, 1'b0);
      chk("R8", "bit-bang word 3", 32'(w), 32'(mem[3]));
      chk("R8", "bit-bang address", 32'(addr_log.size() > 0 ? addr_log.pop_front() : -1), 32'd3);
      chk("R8", "bit-bang frame", 32'(frame_err), 32'd0);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule